// File: doc/BRIEF.md
# Split Simple/Complex Integer Execution Cluster

This block is the integer back end of an out-of-order core. One dispatch port delivers an integer micro-op each cycle. The op arrives with its operation class, both source values already read, a destination tag and a request to update the condition flags. Fast operations are steered to one of several single-cycle simple lanes. Multiply, divide and the complex logical operation go to one shared complex lane. Each lane has its own small reservation station. All lanes share one writeback bus that carries the result and its tag.

The complex lane has a four-stage pipeline that accepts a new multiply every cycle. It also has an iterative divider that is not pipelined: while a divide is in progress the lane takes no other work. A finish stage follows writeback and writes the condition flags one cycle after the result. Consumers of the result therefore see no extra delay, and consumers of the flags see one extra cycle.

Top module: `int_cluster`

## Requirements
- R1: After reset every station is empty. `simpleReady` and `complexReady` are 1, and `wbValid` and `flagWrite` are 0.
- R2: Class codes on `dispClass` are 0 add, 1 subtract, 2 and, 3 or and 4 xor, which are simple. Codes 5 multiply, 6 divide and 7 xnor are complex. A simple op goes to the lowest-numbered empty simple station.
- R3: A simple op produces a 32-bit result on `wbData`, with `wbHigh` = 0. When no complex result competes, the result is on the bus in the cycle after the dispatch edge.
- R4: There are three simple stations, each holding one op. `simpleReady` is 0 while all three are occupied. A simple op presented while `simpleReady` is 0 is dropped and never written back.
- R5: The complex station holds two waiting ops. `complexReady` is 0 while both entries are occupied. A complex op presented while `complexReady` is 0 is dropped.
- R6: Multiply (unsigned, with the low word on `wbData` and the high word on `wbHigh`) and xnor each take four pipeline stages. On an idle lane the result appears 5 cycles after the dispatch edge. Back-to-back ops complete on consecutive cycles.
- R7: Divide is unsigned and retires two quotient bits per cycle over 16 cycles. The quotient goes on `wbData` and the remainder on `wbHigh`. On an idle lane the result appears 18 cycles after the dispatch edge. A divide starts only once the pipeline is empty. No complex op starts until the divide has been written back.
- R8: Dividing by zero gives an all-ones quotient, with the dividend returned as the remainder.
- R9: When lanes finish in the same cycle, the complex lane wins the bus and simple lanes win in index order. A losing lane keeps its result until it is granted.
- R10: For an op dispatched with `dispSetFlags`, `flagWrite` pulses for one cycle, one cycle after its writeback. The pulse carries `flagTag` and `flagBits` (bit 1: result zero, bit 0: result bit 31). Ops without the request never pulse `flagWrite`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispValid | input | 1 | A micro-op is presented |
| dispClass | input | 3 | Operation class code |
| dispSrcA | input | 32 | First source value (dividend) |
| dispSrcB | input | 32 | Second source value (divisor) |
| dispTag | input | 6 | Destination tag |
| dispSetFlags | input | 1 | Op must update the condition flags |
| simpleReady | output | 1 | A simple station is free |
| complexReady | output | 1 | The complex station has room |
| wbValid | output | 1 | Writeback bus carries a result |
| wbTag | output | 6 | Tag of the written-back result |
| wbData | output | 32 | Result, low product word or quotient |
| wbHigh | output | 32 | High product word or remainder |
| flagWrite | output | 1 | Condition flags are written this cycle |
| flagTag | output | 6 | Tag of the op whose flags are written |
| flagBits | output | 2 | {zero, negative} of that result |

## Verification
Assertions check the following properties on every cycle:
- An idle divide lasts exactly sixteen steps.
- The pipeline stays empty while a divide is in progress.
- A full complex station stays full until the lane issues.
- Every bus grant leads to a valid writeback.
- Every flag write follows a writeback of the same tag.

Only the bench's scenarios can show the rest:
- Result values, including division by zero.
- The exact latencies of 1, 5 and 18 cycles.
- The steering of simple ops into the lowest free station, seen through the order in which held results drain.
- The dropping of ops while a ready signal is low.
- The delay a divide imposes on multiplies queued behind it.

// File: rtl/int_cluster_pkg.sv
package int_cluster_pkg;
  localparam int XLEN = 32;
  localparam int TAG_W = 6;
  localparam int SIMPLE_LANES = 3;
  localparam int CX_DEPTH = 2;
  localparam int CX_PTR_W = $clog2(CX_DEPTH);
  localparam int CX_LAT = 4;
  localparam int DIV_CYCLES = 16;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
    OP_XOR = 3'd4, OP_MUL = 3'd5, OP_DIV = 3'd6, OP_XNOR = 3'd7
  } opClass_t;

  typedef struct packed {
    opClass_t cls;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [TAG_W-1:0] tag;
    logic setFlags;
  } uop_t;

  typedef struct packed {
    logic [XLEN-1:0] lo;
    logic [XLEN-1:0] hi;
    logic [TAG_W-1:0] tag;
    logic setFlags;
  } cxRes_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [SIMPLE_LANES-1:0] simpleLoad;
    logic [SIMPLE_LANES-1:0] simpleGrant;
    logic cxPush;
    logic [CX_PTR_W-1:0] cxWrSel;
    logic [CX_PTR_W-1:0] cxRdSel;
    logic pipeIssue;
    logic divStart;
    logic divStep;
    logic wbFromPipe;
    logic wbFromDiv;
  } strobes_t;

  function automatic logic [XLEN-1:0] simpleAlu(opClass_t c, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    case (c)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      default: return a ^ b;
    endcase
  endfunction
endpackage

// File: rtl/int_cluster_ctrl.sv
module int_cluster_ctrl
  import int_cluster_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     dispValid,
  input  opClass_t dispClass,
  input  logic     headIsDiv,
  output strobes_t st,
  output logic     simpleReady,
  output logic     complexReady
);
  localparam int CNT_W = $clog2(CX_DEPTH + 1);
  localparam int DCNT_W = $clog2(DIV_CYCLES + 1);

  logic [SIMPLE_LANES-1:0] simpleBusy, freePick, grantPick;
  logic [CNT_W-1:0] cxCount;
  logic [CX_PTR_W-1:0] wrPtr, rdPtr;
  logic [CX_LAT-1:0] pipeValid;
  logic divBusy, divDone;
  logic [DCNT_W-1:0] divCnt;
  logic isSimple, issue, cxDone;

  always_comb begin
    isSimple = dispClass inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR};
    cxDone = pipeValid[CX_LAT-1] | divDone;
    freePick = '0;
    grantPick = '0;
    for (int i = SIMPLE_LANES - 1; i >= 0; i--) begin
      if (!simpleBusy[i]) begin
        freePick = '0;
        freePick[i] = 1'b1;
      end
      if (simpleBusy[i] && !cxDone) begin
        grantPick = '0;
        grantPick[i] = 1'b1;
      end
    end
    simpleReady = ~&simpleBusy;
    complexReady = cxCount != CNT_W'(CX_DEPTH);
    issue = (cxCount != '0) && !divBusy && !divDone && (!headIsDiv || pipeValid == '0);

    st.simpleLoad  = (dispValid && isSimple) ? freePick : '0;
    st.simpleGrant = grantPick;
    st.cxPush      = dispValid && !isSimple && complexReady;
    st.cxWrSel     = wrPtr;
    st.cxRdSel     = rdPtr;
    st.pipeIssue   = issue && !headIsDiv;
    st.divStart    = issue && headIsDiv;
    st.divStep     = divBusy;
    st.wbFromPipe  = pipeValid[CX_LAT-1];
    st.wbFromDiv   = divDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      simpleBusy <= '0;
      cxCount <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
      pipeValid <= '0;
      divBusy <= 1'b0;
      divDone <= 1'b0;
      divCnt <= '0;
    end else begin
      simpleBusy <= (simpleBusy & ~grantPick) | st.simpleLoad;
      cxCount <= cxCount + CNT_W'(st.cxPush) - CNT_W'(issue);
      if (st.cxPush) wrPtr <= wrPtr + 1'b1;
      if (issue) rdPtr <= rdPtr + 1'b1;
      pipeValid <= {pipeValid[CX_LAT-2:0], st.pipeIssue};
      divDone <= 1'b0;
      if (st.divStart) begin
        divBusy <= 1'b1;
        divCnt <= DCNT_W'(DIV_CYCLES);
      end else if (divBusy) begin
        divCnt <= divCnt - 1'b1;
        if (divCnt == DCNT_W'(1)) begin
          divBusy <= 1'b0;
          divDone <= 1'b1;
        end
      end
    end
  end

  // divide span counter used only by the checks below
  logic [DCNT_W:0] divAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divAge <= '0;
    else if (st.divStart) divAge <= '0;
    else if (divBusy) divAge <= divAge + 1'b1;
  end

  // R7
  div_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(divBusy) |-> divAge == (DCNT_W + 1)'(DIV_CYCLES));

  // R7
  div_solo_chk: assert property (@(posedge clk) disable iff (!rstN)
    divBusy |-> (pipeValid == '0) && !st.pipeIssue);

  // R5
  cx_full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cxCount == CNT_W'(CX_DEPTH) && !issue) |=> cxCount == CNT_W'(CX_DEPTH));

  // R9
  cx_one_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pipeValid[CX_LAT-1] && divDone));
endmodule

// File: rtl/int_cluster_dp.sv
module int_cluster_dp
  import int_cluster_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  uop_t              dispUop,
  output logic              headIsDiv,
  output logic              wbValid,
  output logic [TAG_W-1:0]  wbTag,
  output logic [XLEN-1:0]   wbData,
  output logic [XLEN-1:0]   wbHigh,
  output logic              flagWrite,
  output logic [TAG_W-1:0]  flagTag,
  output logic [1:0]        flagBits
);
  localparam int DIV_PER_CYC = XLEN / DIV_CYCLES;

  logic [SIMPLE_LANES-1:0][XLEN-1:0]  simpleRes;
  logic [SIMPLE_LANES-1:0][TAG_W-1:0] simpleTagV;
  logic [SIMPLE_LANES-1:0]            simpleSetFV;

  for (genvar g = 0; g < SIMPLE_LANES; g++) begin : gSimple
    uop_t slot;
    always_ff @(posedge clk) begin
      if (st.simpleLoad[g]) slot <= dispUop;
    end
    assign simpleRes[g]   = simpleAlu(slot.cls, slot.a, slot.b);
    assign simpleTagV[g]  = slot.tag;
    assign simpleSetFV[g] = slot.setFlags;
  end

  // complex station and pipeline
  uop_t cxSlot [CX_DEPTH];
  uop_t head;
  cxRes_t pipeStage [CX_LAT];
  cxRes_t issueRes;
  logic [2*XLEN-1:0] prod;

  always_ff @(posedge clk) begin
    if (st.cxPush) cxSlot[st.cxWrSel] <= dispUop;
  end

  always_comb begin
    head = cxSlot[st.cxRdSel];
    headIsDiv = head.cls == OP_DIV;
    prod = (2*XLEN)'(head.a) * (2*XLEN)'(head.b);
    issueRes.lo = (head.cls == OP_MUL) ? prod[XLEN-1:0] : ~(head.a ^ head.b);
    issueRes.hi = (head.cls == OP_MUL) ? prod[2*XLEN-1:XLEN] : '0;
    issueRes.tag = head.tag;
    issueRes.setFlags = head.setFlags;
  end

  always_ff @(posedge clk) begin
    pipeStage[0] <= issueRes;
    for (int k = 1; k < CX_LAT; k++) pipeStage[k] <= pipeStage[k-1];
  end

  // restoring divider, DIV_PER_CYC bits per step
  logic [XLEN:0]     divRem, remNext;
  logic [XLEN-1:0]   divQuo, quoNext, divDen;
  logic [TAG_W-1:0]  divTag;
  logic              divSetF;

  always_comb begin
    remNext = divRem;
    quoNext = divQuo;
    for (int s = 0; s < DIV_PER_CYC; s++) begin
      remNext = {remNext[XLEN-1:0], quoNext[XLEN-1]};
      quoNext = {quoNext[XLEN-2:0], 1'b0};
      if (remNext >= {1'b0, divDen}) begin
        remNext = remNext - {1'b0, divDen};
        quoNext[0] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.divStart) begin
      divRem <= '0;
      divQuo <= head.a;
      divDen <= head.b;
      divTag <= head.tag;
      divSetF <= head.setFlags;
    end else if (st.divStep) begin
      divRem <= remNext;
      divQuo <= quoNext;
    end
  end

  // writeback register and trailing finish stage
  logic wbSetF;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbTag <= '0;
      wbData <= '0;
      wbHigh <= '0;
      wbSetF <= 1'b0;
      flagWrite <= 1'b0;
      flagTag <= '0;
      flagBits <= '0;
    end else begin
      flagWrite <= wbValid & wbSetF;
      flagTag <= wbTag;
      flagBits <= {wbData == '0, wbData[XLEN-1]};
      wbValid <= st.wbFromPipe | st.wbFromDiv | (|st.simpleGrant);
      if (st.wbFromPipe) begin
        wbTag <= pipeStage[CX_LAT-1].tag;
        wbData <= pipeStage[CX_LAT-1].lo;
        wbHigh <= pipeStage[CX_LAT-1].hi;
        wbSetF <= pipeStage[CX_LAT-1].setFlags;
      end else if (st.wbFromDiv) begin
        wbTag <= divTag;
        wbData <= divQuo;
        wbHigh <= divRem[XLEN-1:0];
        wbSetF <= divSetF;
      end else begin
        for (int i = 0; i < SIMPLE_LANES; i++) begin
          if (st.simpleGrant[i]) begin
            wbTag <= simpleTagV[i];
            wbData <= simpleRes[i];
            wbHigh <= '0;
            wbSetF <= simpleSetFV[i];
          end
        end
      end
    end
  end

  // R10
  flag_after_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWrite |-> $past(wbValid) && flagTag == $past(wbTag));

  // R9
  wb_cx_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wbFromPipe || st.wbFromDiv) |=> wbValid);

  // R3
  wb_simple_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|st.simpleGrant) |=> wbValid);
endmodule

// File: rtl/int_cluster.sv
module int_cluster
  import int_cluster_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  input  logic [2:0]        dispClass,
  input  logic [XLEN-1:0]   dispSrcA,
  input  logic [XLEN-1:0]   dispSrcB,
  input  logic [TAG_W-1:0]  dispTag,
  input  logic              dispSetFlags,
  output logic              simpleReady,
  output logic              complexReady,
  output logic              wbValid,
  output logic [TAG_W-1:0]  wbTag,
  output logic [XLEN-1:0]   wbData,
  output logic [XLEN-1:0]   wbHigh,
  output logic              flagWrite,
  output logic [TAG_W-1:0]  flagTag,
  output logic [1:0]        flagBits
);
  strobes_t st;
  uop_t dispUop;
  logic headIsDiv;

  assign dispUop = '{cls: opClass_t'(dispClass), a: dispSrcA, b: dispSrcB,
                     tag: dispTag, setFlags: dispSetFlags};

  int_cluster_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispClass(opClass_t'(dispClass)),
    .headIsDiv(headIsDiv), .st(st), .simpleReady(simpleReady), .complexReady(complexReady)
  );

  int_cluster_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .dispUop(dispUop), .headIsDiv(headIsDiv),
    .wbValid(wbValid), .wbTag(wbTag), .wbData(wbData), .wbHigh(wbHigh),
    .flagWrite(flagWrite), .flagTag(flagTag), .flagBits(flagBits)
  );
endmodule

// File: tb/int_cluster_bench.sv
module int_cluster_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispValid = 1'b0;
  logic [2:0] dispClass = '0;
  logic [31:0] dispSrcA = '0, dispSrcB = '0;
  logic [5:0] dispTag = '0;
  logic dispSetFlags = 1'b0;
  logic simpleReady, complexReady, wbValid, flagWrite;
  logic [5:0] wbTag, flagTag;
  logic [31:0] wbData, wbHigh;
  logic [1:0] flagBits;

  always #5 clk = ~clk;

  int_cluster u_int_cluster (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispClass(dispClass),
    .dispSrcA(dispSrcA), .dispSrcB(dispSrcB), .dispTag(dispTag), .dispSetFlags(dispSetFlags),
    .simpleReady(simpleReady), .complexReady(complexReady), .wbValid(wbValid),
    .wbTag(wbTag), .wbData(wbData), .wbHigh(wbHigh), .flagWrite(flagWrite),
    .flagTag(flagTag), .flagBits(flagBits)
  );

  int total = 0, bad = 0, cyc = 0, nOrd = 0;
  bit finished = 0;
  bit pend [64];
  bit seen [64];
  logic [31:0] expLo [64];
  logic [31:0] expHi [64];
  bit expSetF [64];
  string expReq [64];
  int dispEdge [64];
  int lat [64];
  int order [0:1023];
  bit prevFlagExp = 0;
  logic [5:0] prevTag = '0;
  logic [1:0] prevBits = '0;

  always @(posedge clk) cyc++;

  function automatic logic [63:0] model(logic [2:0] c, logic [31:0] a, logic [31:0] b);
    case (c)
      3'd0: return {32'h0, a + b};
      3'd1: return {32'h0, a - b};
      3'd2: return {32'h0, a & b};
      3'd3: return {32'h0, a | b};
      3'd4: return {32'h0, a ^ b};
      3'd5: return {32'h0, a} * {32'h0, b};
      3'd6: return (b == 0) ? {a, 32'hFFFF_FFFF} : {a % b, a / b};
      default: return {32'h0, ~(a ^ b)};
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // result and flag monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (prevFlagExp || flagWrite) begin
        total++;
        if (flagWrite !== prevFlagExp || flagTag !== prevTag || flagBits !== prevBits) begin
          bad++;
          $display("FAIL R10 flag write: act=%0b/%0d/%0b exp=%0b/%0d/%0b",
                   flagWrite, flagTag, flagBits, prevFlagExp, prevTag, prevBits);
        end
      end
      prevFlagExp = 0;
      if (wbValid) begin
        total++;
        if (!pend[wbTag]) begin
          bad++;
          $display("FAIL R4 R5 unexpected tag %0d: act=%0h exp=none", wbTag, wbData);
        end else begin
          if (wbData !== expLo[wbTag] || wbHigh !== expHi[wbTag]) begin
            bad++;
            $display("FAIL %s tag %0d: act=%h_%h exp=%h_%h", expReq[wbTag], wbTag,
                     wbHigh, wbData, expHi[wbTag], expLo[wbTag]);
          end
          lat[wbTag] = cyc - dispEdge[wbTag];
          pend[wbTag] = 0;
          prevFlagExp = expSetF[wbTag];
          prevTag = wbTag;
          prevBits = {expLo[wbTag] == 32'h0, expLo[wbTag][31]};
        end
        seen[wbTag] = 1;
        if (nOrd < 1024) order[nOrd] = int'(wbTag);
        nOrd++;
      end
    end
  end

  function automatic int posOf(int tag);
    int p = -1;
    for (int i = 0; i < nOrd && i < 1024; i++) if (order[i] == tag) p = i;
    return p;
  endfunction

  task automatic send(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                      input int tag, input bit sf);
    logic [63:0] m;
    @(posedge clk); #1;
    while (!((c <= 3'd4) ? simpleReady : complexReady) || pend[tag]) begin
      dispValid = 1'b0;
      @(posedge clk); #1;
    end
    dispValid = 1'b1; dispClass = c; dispSrcA = a; dispSrcB = b;
    dispTag = 6'(tag); dispSetFlags = sf;
    m = model(c, a, b);
    expLo[tag] = m[31:0]; expHi[tag] = m[63:32]; expSetF[tag] = sf;
    expReq[tag] = (c <= 3'd4) ? "R3" : (c == 3'd6) ? ((b == 0) ? "R8" : "R7") : "R6";
    dispEdge[tag] = cyc + 1; lat[tag] = -1; seen[tag] = 0; pend[tag] = 1;
  endtask

  task automatic dropTry(input logic [2:0] c, input int tag);
    @(posedge clk); #1;
    dispValid = 1'b1; dispClass = c; dispSrcA = 32'd9; dispSrcB = 32'd3;
    dispTag = 6'(tag); dispSetFlags = 1'b0; seen[tag] = 0;
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    dispValid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL all watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin pend[i] = 0; seen[i] = 0; lat[i] = -1; end
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(simpleReady === 1'b1, "R1", "simpleReady", simpleReady, 1);
    check(complexReady === 1'b1, "R1", "complexReady", complexReady, 1);
    check(wbValid === 1'b0, "R1", "wbValid", wbValid, 0);
    check(flagWrite === 1'b0, "R1", "flagWrite", flagWrite, 0);

    // R2 R3: each simple class, single-cycle latency, flags for zero and negative (R10)
    send(3'd0, 32'd5, 32'd7, 1, 1'b0);
    send(3'd1, 32'd10, 32'd10, 2, 1'b1);
    send(3'd2, 32'hF0F0, 32'h0FF0, 3, 1'b0);
    send(3'd3, 32'h1200, 32'h0034, 4, 1'b0);
    send(3'd4, 32'hFFFF, 32'h00FF, 5, 1'b0);
    send(3'd1, 32'd3, 32'd5, 6, 1'b1);
    idle(4);
    for (int t = 1; t <= 6; t++) check(lat[t] == 1, "R3", "simple latency", lat[t], 1);

    // R4 R6 R9: multiplies hold the bus while simple lanes fill in order
    for (int t = 10; t <= 13; t++) send(3'd5, 32'hFFFF_0000 + 32'(t), 32'd1000 + 32'(t), t, t == 12);
    send(3'd0, 32'd1, 32'd2, 14, 1'b0);
    send(3'd1, 32'd1, 32'd2, 15, 1'b1);
    send(3'd4, 32'd1, 32'd2, 16, 1'b0);
    @(posedge clk); #1;
    check(simpleReady === 1'b0, "R4", "simpleReady with three held", simpleReady, 0);
    dispValid = 1'b1; dispClass = 3'd0; dispTag = 6'd17; dispSetFlags = 1'b0; seen[17] = 0;
    idle(12);
    for (int t = 10; t <= 13; t++) check(lat[t] == 5, "R6", "multiply latency", lat[t], 5);
    for (int t = 10; t <= 15; t++)
      check(posOf(t + 1) == posOf(t) + 1, "R9", "drain order", posOf(t + 1), posOf(t) + 1);
    check(lat[14] == 5, "R9", "held simple result", lat[14], 5);
    check(seen[17] == 0, "R4", "dropped simple op written back", seen[17], 0);

    // R5 R7: divide blocks queued multiplies, full station drops
    send(3'd6, 32'd1000, 32'd7, 20, 1'b1);
    send(3'd5, 32'd6, 32'd7, 21, 1'b0);
    send(3'd7, 32'h0F0F_0000, 32'h00FF_00FF, 22, 1'b1);
    @(posedge clk); #1;
    check(complexReady === 1'b0, "R5", "complexReady with two waiting", complexReady, 0);
    dropTry(3'd5, 23);
    idle(30);
    check(lat[20] == 18, "R7", "divide latency", lat[20], 18);
    check(lat[21] == 22, "R7", "multiply behind divide", lat[21], 22);
    check(lat[22] == 22, "R7", "xnor behind divide", lat[22], 22);
    check(seen[23] == 0, "R5", "dropped complex op written back", seen[23], 0);

    // R8 divide by zero, plus divide boundaries
    send(3'd6, 32'h1234_5678, 32'd0, 30, 1'b1);
    send(3'd6, 32'hFFFF_FFFF, 32'd1, 31, 1'b0);
    idle(45);
    check(seen[30] == 1, "R8", "divide by zero completed", seen[30], 1);

    // random mix, all requirements via the monitor
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [2:0] c;
      logic [31:0] b;
      r = $urandom_range(0, 9);
      c = (r <= 4) ? 3'(r) : (r <= 6) ? 3'd5 : (r == 7) ? 3'd7 : 3'd6;
      b = ($urandom_range(0, 5) == 0) ? 32'd0 : (($urandom_range(0, 1) == 1) ? 32'($urandom_range(1, 300)) : $urandom);
      send(c, $urandom, b, 32 + (n % 32), $urandom_range(0, 1) == 1);
    end
    idle(80);
    for (int t = 0; t < 64; t++)
      if (pend[t]) check(1'b0, "R3", "op never written back", t, -1);
    check(nOrd > 400, "R2", "writebacks observed", nOrd, 400);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule